// File: doc/BRIEF.md
# Microwire Serial EEPROM Host Engine

This block sits on the host side of a three-wire serial EEPROM link. It drives chip select, serial clock and serial data toward the memory and samples the memory's data output. A command port takes one request at a time: an operation code, an address, write data, a word-width select and a count of extra words for a streaming read. The engine builds the serial frame and its length from the operation and the width. It returns read words one by one with a valid strobe. At the end of each command it gives a one-cycle completion pulse.

For commands that program the array, the engine does not wait a fixed time. It closes the frame, holds chip select low for a minimum gap, and then raises it again. It then watches the data line until the memory reports ready. A single start bit clears the status from the line before select is dropped. A poll that runs past a limit ends the command with an error flag. The serial clock half-period, the minimum select-low gap and the poll limit are parameters counted in system clock cycles.

Top module: `mw_eeprom_host`

## Requirements
- R1: While reset is held, select, serial clock, `done`, `rd_valid` and `err` are all low, and `cmd_ready` is high.
- R2: `cmd_ready` is high only while the engine is idle. A command is taken in a cycle where both `cmd_valid` and `cmd_ready` are high. From the cycle after acceptance until the command ends, `cmd_ready` stays low.
- R3: In 16-bit mode (`cmd_x16`=1) the frame holds these numbers of serial clocks: 29 for WRITE and WRAL; 13 for ERASE, ERAL, EWEN and EWDS; 13 plus 16 per word for READ.
- R4: In 8-bit mode the frame holds these numbers of serial clocks: 22 for WRITE and WRAL; 14 for ERASE, ERAL, EWEN and EWDS; 14 plus 8 per word for READ.
- R5: Every frame is sent MSB first. It starts with a 1, followed by a two-bit code, followed by an address field of 10 bits (16-bit mode) or 11 bits (8-bit mode), followed by the data for WRITE and WRAL.
  - Two-bit codes: READ 10, WRITE 01, ERASE 11, and 00 for the four global commands.
  - For a global command, the top two address bits select it: EWEN 11, ERAL 10, WRAL 01, EWDS 00. The remaining address bits are 0.
  - `cmd_op` encoding: READ 0, WRITE 1, ERASE 2, ERAL 3, WRAL 4, EWEN 5, EWDS 6.
- R6: Serial data changes only while the serial clock is low. Select rises only while both the serial clock and serial data are low.
- R7: A READ discards the one data-line bit that follows the last address clock. It then assembles each word MSB first into `rd_data`. In 8-bit mode the word sits in bits 7:0 and bits 15:8 are zero.
- R8: A READ returns `cmd_more`+1 words from consecutive addresses, in one select-high period, with one `rd_valid` pulse per word.
- R9: After the frame of WRITE, ERASE, ERAL or WRAL, select is held low for at least CSL_MIN cycles. It is then raised, and the data line is polled until it reads 1. One clock with serial data 1 is then sent, and select is dropped.
- R10: If the data line has not read 1 within POLL_MAX cycles of polling, the command ends with `err` high at `done`. `err` stays high until the next command is accepted, and it is low at the end of a command that finishes normally.
- R11: `done` is a one-cycle pulse at the end of every command. Select has been low for at least CSL_MIN cycles when it occurs.
- R12: Each high phase of the serial clock lasts exactly CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command may be taken |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 11 | Word address (bits 9:0 used in 16-bit mode) |
| cmd_wdata | input | 16 | Write data (bits 7:0 used in 8-bit mode) |
| cmd_x16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cmd_more | input | LEN_W | Extra words for a streaming read |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Ready poll timed out |
| mw_cs | output | 1 | Serial chip select |
| mw_clk | output | 1 | Serial clock |
| mw_di | output | 1 | Serial data toward the memory |
| mw_do | input | 1 | Serial data from the memory |

## Verification
The engine runs against a behavioural memory model that decodes the serial frames. The model counts the clocks in each select-high period and applies writes only when they are enabled. Framing is tried with every operation in both word widths, and each frame's clock count is compared with the expected length. A single-word read and streaming reads of several words use data whose top bits are set, so that a dummy bit that is not skipped shows up as a shifted word. Writing while programming is disabled, then reading back, tells a correctly coded enable apart from a wrong one. A memory held busy past the poll limit tells polling with a timeout apart from a fixed wait.

// File: rtl/mw_eeprom_host.sv
`timescale 1ns/1ps
module mw_eeprom_host #(
  parameter int CLK_DIV  = 2,
  parameter int CSL_MIN  = 8,
  parameter int POLL_MAX = 200,
  parameter int LEN_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [10:0]      cmd_addr,
  input  logic [15:0]      cmd_wdata,
  input  logic             cmd_x16,
  input  logic [LEN_W-1:0] cmd_more,
  output logic             rd_valid,
  output logic [15:0]      rd_data,
  output logic             done,
  output logic             err,
  output logic             mw_cs,
  output logic             mw_clk,
  output logic             mw_di,
  input  logic             mw_do
);
  localparam int DW = $clog2((CLK_DIV > CSL_MIN ? CLK_DIV : CSL_MIN) + 1);
  localparam int TW = $clog2(POLL_MAX + 1);
  localparam int CW = $clog2(14 + 16 * (1 << LEN_W) + 1);
  localparam logic [2:0] OP_READ = 3'd0, OP_WRITE = 3'd1, OP_ERASE = 3'd2,
                         OP_ERAL = 3'd3, OP_WRAL = 3'd4, OP_EWEN = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_GAP, S_POLL, S_END} st_t;

  st_t            st;
  logic [DW-1:0]  div;
  logic [TW-1:0]  tmo;
  logic [CW-1:0]  bitn, total, ftot;
  logic [31:0]    sh, frame;
  logic [2:0]     op_q;
  logic           x16_q, clr;
  logic [3:0]     wb;
  logic [15:0]    rx;
  logic [1:0]     opc, spc;
  logic [9:0]     a16;
  logic [10:0]    a8;

  wire special = (cmd_op >= OP_ERAL);
  wire tick    = (div == DW'(CLK_DIV - 1));
  wire gap_end = (div == DW'(CSL_MIN - 1));
  wire prog    = (op_q == OP_WRITE) || (op_q == OP_ERASE) || (op_q == OP_ERAL) || (op_q == OP_WRAL);
  wire capture = (op_q == OP_READ) && (bitn >= CW'(x16_q ? 13 : 14));
  wire wlast   = (wb == (x16_q ? 4'd15 : 4'd7));

  always_comb begin
    case (cmd_op)
      OP_READ:  opc = 2'b10;
      OP_WRITE: opc = 2'b01;
      OP_ERASE: opc = 2'b11;
      default:  opc = 2'b00;
    endcase
    case (cmd_op)
      OP_ERAL: spc = 2'b10;
      OP_WRAL: spc = 2'b01;
      OP_EWEN: spc = 2'b11;
      default: spc = 2'b00;
    endcase
    a16   = special ? {spc, 8'b0} : cmd_addr[9:0];
    a8    = special ? {spc, 9'b0} : cmd_addr;
    frame = cmd_x16 ? {1'b1, opc, a16, cmd_wdata, 3'b0}
                    : {1'b1, opc, a8, cmd_wdata[7:0], 10'b0};
    if (cmd_op == OP_READ)
      ftot = cmd_x16 ? CW'(13 + 16 * (int'(cmd_more) + 1)) : CW'(14 + 8 * (int'(cmd_more) + 1));
    else if (cmd_op == OP_WRITE || cmd_op == OP_WRAL)
      ftot = cmd_x16 ? CW'(29) : CW'(22);
    else
      ftot = cmd_x16 ? CW'(13) : CW'(14);
  end

  assign cmd_ready = (st == S_IDLE);
  assign mw_cs     = (st == S_SETUP) || (st == S_LOW) || (st == S_HIGH) || (st == S_POLL);
  assign mw_clk    = (st == S_HIGH);
  assign mw_di     = ((st == S_LOW) || (st == S_HIGH)) && sh[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; tmo <= '0; bitn <= '0; total <= '0; sh <= '0;
      op_q <= '0; x16_q <= 1'b0; clr <= 1'b0; wb <= '0; rx <= '0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q <= cmd_op; x16_q <= cmd_x16; sh <= frame; total <= ftot;
          bitn <= '0; clr <= 1'b0; err <= 1'b0; div <= '0; wb <= '0;
          st <= S_SETUP;
        end
        S_SETUP, S_LOW: if (tick) begin
          div <= '0;
          st  <= (st == S_SETUP) ? S_LOW : S_HIGH;
        end else div <= div + DW'(1);
        S_HIGH: if (tick) begin
          div  <= '0;
          sh   <= sh << 1;
          bitn <= bitn + CW'(1);
          if (capture) begin
            rx <= {rx[14:0], mw_do};
            if (wlast) begin
              rd_valid <= 1'b1;
              rd_data  <= x16_q ? {rx[14:0], mw_do} : {8'h00, rx[6:0], mw_do};
              wb       <= '0;
            end else wb <= wb + 4'd1;
          end
          if (bitn == total - CW'(1)) st <= (prog && !clr) ? S_GAP : S_END;
          else                        st <= S_LOW;
        end else div <= div + DW'(1);
        S_GAP: if (gap_end) begin
          div <= '0; tmo <= '0; st <= S_POLL;
        end else div <= div + DW'(1);
        S_POLL: if (tmo >= TW'(CLK_DIV) && mw_do) begin
          sh <= 32'h8000_0000; total <= CW'(1); bitn <= '0; clr <= 1'b1; div <= '0;
          st <= S_LOW;
        end else if (tmo == TW'(POLL_MAX - 1)) begin
          err <= 1'b1; div <= '0; st <= S_END;
        end else tmo <= tmo + TW'(1);
        S_END: if (gap_end) begin
          done <= 1'b1; st <= S_IDLE;
        end else div <= div + DW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mw_cs && !mw_clk));
  assert_cs_rise_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> (!mw_clk && !mw_di));
  assert_di_hold_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_clk && $past(mw_clk)) |-> $stable(mw_di));
  assert_rd_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (op_q == OP_READ));
  assert_err_at_cs_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !mw_cs);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_cs_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mw_cs && !$past(mw_cs)));
endmodule

// File: tb/mw_eeprom_host_bench.sv
`timescale 1ns/1ps
module mw_eeprom_host_bench;
  localparam int CLK_DIV = 2, CSL_MIN = 8, POLL_MAX = 200, LEN_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_x16 = 1'b1;
  logic [2:0] cmd_op = '0;
  logic [10:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [LEN_W-1:0] cmd_more = '0;
  logic cmd_ready, rd_valid, done, err, mw_cs, mw_clk, mw_di, mw_do;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  mw_eeprom_host #(.CLK_DIV(CLK_DIV), .CSL_MIN(CSL_MIN), .POLL_MAX(POLL_MAX), .LEN_W(LEN_W)) u_mw_eeprom_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_x16(cmd_x16), .cmd_more(cmd_more),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
    .mw_cs(mw_cs), .mw_clk(mw_clk), .mw_di(mw_di), .mw_do(mw_do));

  // ---------------- memory model ----------------
  logic [7:0] mem8 [0:2047];
  logic m_x16 = 1'b1;
  logic en = 1'b0, st_en = 1'b0, rdy = 1'b1, dout = 1'b1, started = 1'b0, rd_on = 1'b0;
  int busy_ns = 300;
  int sess_total = 0, sess_clks = 0;
  int clk_log [0:63];
  int nb, aw, ww, op2, code, ma, ow;
  int hdr, dsh;
  logic [15:0] osh;
  event busy_kick;

  initial begin
    for (int i = 0; i < 2048; i++) mem8[i] = 8'h00;
    for (int i = 0; i < 64; i++) clk_log[i] = 0;
  end

  initial forever begin
    @(busy_kick);
    rdy = 1'b0;
    #(busy_ns);
    rdy = 1'b1;
  end

  assign mw_do = (st_en && mw_cs) ? rdy : dout;

  function automatic logic [15:0] fetch(int a);
    return m_x16 ? {mem8[2*a], mem8[2*a+1]} : {8'h00, mem8[a]};
  endfunction

  always @(posedge mw_clk or negedge mw_cs) begin
    if (!mw_cs) begin
      clk_log[sess_total % 64] = sess_clks;
      sess_total++;
      sess_clks = 0; started = 1'b0; rd_on = 1'b0; dout = 1'b1;
    end else begin
      sess_clks++;
      aw = m_x16 ? 10 : 11;
      ww = m_x16 ? 16 : 8;
      if (!started) begin
        if (mw_di) begin started = 1'b1; nb = 0; hdr = 0; dsh = 0; st_en = 1'b0; end
      end else if (rd_on) begin
        dout = osh[ww-1];
        osh = osh << 1;
        ow++;
        if (ow == ww) begin ma = (ma + 1) & ((1 << aw) - 1); osh = fetch(ma); ow = 0; end
      end else begin
        nb++;
        if (nb <= 2 + aw) hdr = (hdr << 1) | int'(mw_di);
        else              dsh = (dsh << 1) | int'(mw_di);
        if (nb == 2 + aw) begin
          op2 = (hdr >> aw) & 3; ma = hdr & ((1 << aw) - 1); code = (hdr >> (aw - 2)) & 3;
          if (op2 == 2) begin rd_on = 1'b1; osh = fetch(ma); ow = 0; dout = 1'b0; end
          else if (op2 == 3) begin
            if (en) begin
              if (m_x16) begin mem8[2*ma] = 8'hFF; mem8[2*ma+1] = 8'hFF; end else mem8[ma] = 8'hFF;
              -> busy_kick;
            end
            st_en = 1'b1;
          end else if (op2 == 0) begin
            if (code == 3) en = 1'b1;
            else if (code == 0) en = 1'b0;
            else if (code == 2) begin
              if (en) begin for (int i = 0; i < 2048; i++) mem8[i] = 8'hFF; -> busy_kick; end
              st_en = 1'b1;
            end
          end
        end
        if (nb == 2 + aw + ww) begin
          if (op2 == 1) begin
            if (en) begin
              if (m_x16) begin mem8[2*ma] = 8'(dsh >> 8); mem8[2*ma+1] = 8'(dsh); end
              else mem8[ma] = 8'(dsh);
              -> busy_kick;
            end
            st_en = 1'b1;
          end else if (op2 == 0 && code == 1) begin
            if (en) begin
              for (int i = 0; i < 2048; i++) mem8[i] = m_x16 ? ((i % 2 == 0) ? 8'(dsh >> 8) : 8'(dsh)) : 8'(dsh);
              -> busy_kick;
            end
            st_en = 1'b1;
          end
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  int n_chk = 0, n_bad = 0;
  int di_bad = 0, cs_bad = 0, gap_bad = 0, hw_bad = 0;
  int cyc = 0, lowcnt = 1000, hicnt = 0;
  logic p_clk = 1'b0, p_di = 1'b0, p_cs = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mw_clk && p_clk && mw_di != p_di) di_bad++;
      if (mw_cs && !p_cs) begin
        if (mw_clk || mw_di) cs_bad++;
        if (lowcnt < CSL_MIN) gap_bad++;
      end
      if (!mw_clk && p_clk && hicnt != CLK_DIV) hw_bad++;
    end
    lowcnt = mw_cs ? 0 : lowcnt + 1;
    hicnt  = mw_clk ? hicnt + 1 : 0;
    p_clk = mw_clk; p_di = mw_di; p_cs = mw_cs;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [2:0] RD = 0, WR = 1, ER = 2, EA = 3, WA = 4, EN = 5, DS = 6;
  logic [15:0] words [0:15];
  int nwords, base, got_err;

  task automatic run_cmd(input logic [2:0] op, input int a, input int d, input logic x16, input int more);
    int guard;
    m_x16 = x16; nwords = 0; base = sess_total; guard = 0;
    @(negedge clk);
    cmd_op = op; cmd_addr = 11'(a); cmd_wdata = 16'(d); cmd_x16 = x16; cmd_more = LEN_W'(more);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2", "ready low after accept", 32'(cmd_ready), 32'd0);
    while (!done && guard < 20000) begin
      if (rd_valid && nwords < 16) begin words[nwords] = rd_data; nwords++; end
      @(negedge clk);
      guard++;
    end
    got_err = int'(err);
    @(negedge clk);
    chk("R11", "done is one cycle", 32'(done), 32'd0);
    chk("R2", "ready after done", 32'(cmd_ready), 32'd1);
  endtask

  function automatic int frame_clks();
    return clk_log[base % 64];
  endfunction

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "cs", 32'(mw_cs), 0);   chk("R1", "sclk", 32'(mw_clk), 0);
    chk("R1", "done", 32'(done), 0);  chk("R1", "rd_valid", 32'(rd_valid), 0);
    chk("R1", "err", 32'(err), 0);    chk("R1", "ready", 32'(cmd_ready), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_enable_x16;
    run_cmd(EN, 0, 0, 1'b1, 0);
    chk("R3", "EWEN x16 clocks", 32'(frame_clks()), 13);
    chk("R9", "EWEN no poll session", 32'(sess_total - base), 1);
  endtask

  task automatic t_write_read_x16;
    run_cmd(WR, 'h155, 'hA5C3, 1'b1, 0);
    chk("R3", "WRITE x16 clocks", 32'(frame_clks()), 29);
    chk("R9", "WRITE sessions", 32'(sess_total - base), 2);
    chk("R9", "status cleared", 32'(st_en), 0);
    chk("R10", "no err", 32'(got_err), 0);
    run_cmd(RD, 'h155, 0, 1'b1, 0);
    chk("R3", "READ x16 clocks", 32'(frame_clks()), 29);
    chk("R8", "one word", 32'(nwords), 1);
    chk("R7", "x16 data", 32'(words[0]), 'hA5C3);
  endtask

  task automatic t_write_read_x8;
    run_cmd(WR, 'h7FF, 'h3C, 1'b0, 0);
    chk("R4", "WRITE x8 clocks", 32'(frame_clks()), 22);
    run_cmd(RD, 'h7FF, 0, 1'b0, 0);
    chk("R4", "READ x8 clocks", 32'(frame_clks()), 22);
    chk("R7", "x8 data zero-extended", 32'(words[0]), 'h003C);
  endtask

  task automatic t_seq_x16;
    run_cmd(WR, 'h020, 'h8001, 1'b1, 0);
    run_cmd(WR, 'h021, 'hC3F0, 1'b1, 0);
    run_cmd(WR, 'h022, 'h7E5A, 1'b1, 0);
    run_cmd(RD, 'h020, 0, 1'b1, 2);
    chk("R3", "seq READ x16 clocks", 32'(frame_clks()), 61);
    chk("R8", "x16 word count", 32'(nwords), 3);
    chk("R8", "x16 w0", 32'(words[0]), 'h8001);
    chk("R8", "x16 w1", 32'(words[1]), 'hC3F0);
    chk("R8", "x16 w2", 32'(words[2]), 'h7E5A);
  endtask

  task automatic t_seq_x8;
    run_cmd(WR, 'h300, 'h81, 1'b0, 0);
    run_cmd(WR, 'h301, 'h42, 1'b0, 0);
    run_cmd(WR, 'h302, 'hFF, 1'b0, 0);
    run_cmd(WR, 'h303, 'h00, 1'b0, 0);
    run_cmd(RD, 'h300, 0, 1'b0, 3);
    chk("R4", "seq READ x8 clocks", 32'(frame_clks()), 46);
    chk("R8", "x8 word count", 32'(nwords), 4);
    chk("R8", "x8 b0", 32'(words[0]), 'h81); chk("R8", "x8 b1", 32'(words[1]), 'h42);
    chk("R8", "x8 b2", 32'(words[2]), 'hFF); chk("R8", "x8 b3", 32'(words[3]), 'h00);
  endtask

  task automatic t_erase;
    run_cmd(ER, 'h021, 0, 1'b1, 0);
    chk("R3", "ERASE x16 clocks", 32'(frame_clks()), 13);
    chk("R9", "ERASE sessions", 32'(sess_total - base), 2);
    run_cmd(RD, 'h021, 0, 1'b1, 0);
    chk("R5", "erased word", 32'(words[0]), 'hFFFF);
    run_cmd(RD, 'h020, 0, 1'b1, 0);
    chk("R5", "neighbour kept", 32'(words[0]), 'h8001);
  endtask

  task automatic t_global;
    run_cmd(EA, 0, 0, 1'b0, 0);
    chk("R4", "ERAL x8 clocks", 32'(frame_clks()), 14);
    run_cmd(RD, 'h155, 0, 1'b1, 0);
    chk("R5", "ERAL cleared", 32'(words[0]), 'hFFFF);
    run_cmd(WA, 0, 'h5A96, 1'b1, 0);
    chk("R3", "WRAL x16 clocks", 32'(frame_clks()), 29);
    run_cmd(RD, 'h3FF, 0, 1'b1, 0);
    chk("R5", "WRAL top", 32'(words[0]), 'h5A96);
    run_cmd(RD, 'h000, 0, 1'b1, 0);
    chk("R5", "WRAL bottom", 32'(words[0]), 'h5A96);
  endtask

  task automatic t_disable;
    run_cmd(DS, 0, 0, 1'b1, 0);
    chk("R3", "EWDS x16 clocks", 32'(frame_clks()), 13);
    run_cmd(WR, 'h040, 'h1111, 1'b1, 0);
    run_cmd(RD, 'h040, 0, 1'b1, 0);
    chk("R5", "write ignored when disabled", 32'(words[0]), 'h5A96);
    run_cmd(EN, 0, 0, 1'b0, 0);
    chk("R4", "EWEN x8 clocks", 32'(frame_clks()), 14);
  endtask

  task automatic t_timeout;
    busy_ns = 4000;
    run_cmd(WR, 'h041, 'h2222, 1'b1, 0);
    chk("R10", "err at timeout", 32'(got_err), 1);
    chk("R10", "poll session without clear", 32'(sess_total - base), 2);
    repeat (5) @(negedge clk);
    chk("R10", "err held", 32'(err), 1);
    wait (rdy);
    #100;
    busy_ns = 300;
    run_cmd(DS, 0, 0, 1'b1, 0);
    chk("R10", "err cleared by next command", 32'(got_err), 0);
  endtask

  initial begin
    t_reset;
    t_enable_x16;
    t_write_read_x16;
    t_write_read_x8;
    t_seq_x16;
    t_seq_x8;
    t_erase;
    t_global;
    t_disable;
    t_timeout;
    chk("R6", "DI moved while SCLK high", 32'(di_bad), 0);
    chk("R6", "CS rose with SCLK or DI high", 32'(cs_bad), 0);
    chk("R11", "CS low gap short", 32'(gap_bad), 0);
    chk("R12", "SCLK high width", 32'(hw_bad), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule